// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block measures how long a processor keeps each of its two interrupt mask bits set. The general mask (I) and the non-maskable-request mask (X) are watched side by side against a free-running cycle count. The core supplies a strobe at every instruction boundary, and the mask bits and the count are sampled only on that strobe.

For each mask bit the block keeps three statistics: the shortest, the longest and the most recent closed masked interval. It also shows the length of an interval that is still open. The shortest-interval register resets to all ones, which means nothing has been measured yet. While it still holds that value, its output shows the longest value in its place. The statistics come out on plain ports for debug logic or a trace unit to read.

Top module: `mask_dur_mon`

## Requirements
- R1: After reset each channel shows maximum 0, last 0, open flag 0, running length 0 and minimum output 0.
- R2: A strobe with a channel's mask bit at 1 and no open interval opens an interval and records the cycle count as its start. The running output then reads count minus start.
- R3: A strobe with the mask bit still 1 while an interval is open does not move the recorded start.
- R4: A strobe with the mask bit at 0 while an interval is open closes it. The last output becomes count minus start, taken modulo 2^CW, so a count that has wrapped still gives the true length.
- R5: When an interval closes, the stored minimum is replaced if the new length is smaller.
- R6: When an interval closes, the maximum is replaced if the new length is larger. The maximum never decreases except at reset.
- R7: On a strobe with the mask bit still 1 and an interval open, the maximum rises to the running length if that length is larger.
- R8: While the stored minimum still holds its all-ones reset value, the minimum output shows the maximum instead. The minimum output is never above the maximum.
- R9: With the strobe low, changes on the mask bits and on the count have no effect on any statistic or on the open flag.
- R10: The I channel and the X channel are independent. Activity on one channel never changes the other channel's outputs.
- R11: While no interval is open, the running output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Instruction-boundary sample strobe |
| mask_i | input | 1 | General interrupt mask bit |
| mask_x | input | 1 | Non-maskable-request mask bit |
| cyc_cnt | input | CW | Free-running cycle count |
| i_min | output | CW | I channel shortest interval (shows the maximum while unmeasured) |
| i_max | output | CW | I channel longest interval |
| i_last | output | CW | I channel most recent closed interval |
| i_run | output | CW | I channel running length of the open interval |
| i_open | output | 1 | I channel interval open |
| x_min | output | CW | X channel shortest interval (shows the maximum while unmeasured) |
| x_max | output | CW | X channel longest interval |
| x_last | output | CW | X channel most recent closed interval |
| x_run | output | CW | X channel running length of the open interval |
| x_open | output | 1 | X channel interval open |

## Verification
The bench holds the mask bit set across several strobes. A design that restarted the interval on each strobe would report lengths that are too short, and one that never raised the maximum while the interval is open would leave the maximum at 0. It reads the minimum output before any interval on X has closed; a design without the fallback would show 0xFFFF. It closes an interval across a wrap of the cycle count, which a design with a signed or widened subtraction would get wrong. It also toggles the mask with the strobe low and drives only one channel at a time, so that a channel which ignored the strobe, or leaked state into the other channel, changes outputs that should stay fixed.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_I = 1'b0, CH_X = 1'b1} mdm_ch_e;
endpackage

// File: rtl/mdm_channel.sv
module mdm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          mask,
  input  logic [CW-1:0] cyc,
  output logic [CW-1:0] min_raw,
  output logic [CW-1:0] max_q,
  output logic [CW-1:0] last_q,
  output logic [CW-1:0] run,
  output logic          open_q
);
  localparam logic [CW-1:0] SENTINEL = '1;

  logic [CW-1:0] start_q;
  logic [CW-1:0] len;

  // modulo-2^CW difference handles a wrapped count
  assign len = cyc - start_q;
  assign run = open_q ? len : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      open_q  <= 1'b0;
      min_raw <= SENTINEL;
      max_q   <= '0;
      last_q  <= '0;
    end else if (stb) begin
      if (mask) begin
        if (!open_q) begin
          start_q <= cyc;
          open_q  <= 1'b1;
        end else if (len > max_q) begin
          max_q <= len;
        end
      end else if (open_q) begin
        last_q <= len;
        open_q <= 1'b0;
        if (len < min_raw) min_raw <= len;
        if (len > max_q)   max_q   <= len;
      end
    end
  end
endmodule

// File: rtl/mdm_min_view.sv
module mdm_min_view #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] min_raw,
  input  logic [CW-1:0] max_q,
  output logic [CW-1:0] min_out
);
  localparam logic [CW-1:0] SENTINEL = '1;
  assign min_out = (min_raw == SENTINEL) ? max_q : min_raw;
endmodule

// File: rtl/mask_dur_mon.sv
module mask_dur_mon
  import mdm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic          mask_i,
  input  logic          mask_x,
  input  logic [CW-1:0] cyc_cnt,
  output logic [CW-1:0] i_min,
  output logic [CW-1:0] i_max,
  output logic [CW-1:0] i_last,
  output logic [CW-1:0] i_run,
  output logic          i_open,
  output logic [CW-1:0] x_min,
  output logic [CW-1:0] x_max,
  output logic [CW-1:0] x_last,
  output logic [CW-1:0] x_run,
  output logic          x_open
);
  logic [NUM_CH-1:0]         masks;
  logic [NUM_CH-1:0][CW-1:0] min_raw, max_v, last_v, run_v, min_v;
  logic [NUM_CH-1:0]         open_v;

  assign masks[CH_I] = mask_i;
  assign masks[CH_X] = mask_x;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mdm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .mask(masks[c]), .cyc(cyc_cnt),
      .min_raw(min_raw[c]), .max_q(max_v[c]), .last_q(last_v[c]),
      .run(run_v[c]), .open_q(open_v[c])
    );
    mdm_min_view #(.CW(CW)) u_view (
      .min_raw(min_raw[c]), .max_q(max_v[c]), .min_out(min_v[c])
    );
  end

  assign i_min  = min_v[CH_I];
  assign i_max  = max_v[CH_I];
  assign i_last = last_v[CH_I];
  assign i_run  = run_v[CH_I];
  assign i_open = open_v[CH_I];
  assign x_min  = min_v[CH_X];
  assign x_max  = max_v[CH_X];
  assign x_last = last_v[CH_X];
  assign x_run  = run_v[CH_X];
  assign x_open = open_v[CH_X];
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          mask_i,
  input logic          mask_x,
  input logic [CW-1:0] cyc_cnt,
  input logic [CW-1:0] i_min, i_max, i_last, i_run,
  input logic          i_open,
  input logic [CW-1:0] x_min, x_max, x_last, x_run,
  input logic          x_open
);
  // R2
  i_open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_open) |-> $past(smp_stb && mask_i));
  // R4
  i_last_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(i_open) |-> i_last == $past(i_run));
  // R4
  x_last_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(x_open) |-> x_last == $past(x_run));
  // R6
  i_max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_max >= $past(i_max));
  // R6
  x_max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_max >= $past(x_max));
  // R8
  i_min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_min <= i_max);
  // R8
  x_min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_min <= x_max);
  // R9
  i_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> ($stable(i_last) && $stable(i_max) && $stable(i_open)));
  // R9
  x_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> ($stable(x_last) && $stable(x_max) && $stable(x_open)));
endmodule

bind mask_dur_mon mdm_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_mask_dur_mon.sv
module tb_mask_dur_mon;
  localparam int CW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0, mask_i = 1'b0, mask_x = 1'b0;
  logic [CW-1:0] cyc_cnt = '0;
  logic [CW-1:0] i_min, i_max, i_last, i_run, x_min, x_max, x_last, x_run;
  logic i_open, x_open;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mask_dur_mon #(.CW(CW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at next negedge
  task automatic step(input logic s, input logic mi, input logic mx, input int c);
    @(negedge clk);
    smp_stb = s; mask_i = mi; mask_x = mx; cyc_cnt = CW'(c);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 i_max", int'(i_max), 0);   chk("R1 i_last", int'(i_last), 0);
    chk("R1 i_open", int'(i_open), 0); chk("R1 i_min", int'(i_min), 0);
    chk("R1 x_min", int'(x_min), 0);   chk("R11 x_run", int'(x_run), 0);
  endtask

  task automatic t_first_interval();
    step(1, 1, 0, 100);
    chk("R2 i_open", int'(i_open), 1); chk("R2 i_run", int'(i_run), 0);
    step(1, 1, 0, 105);
    chk("R3 i_run", int'(i_run), 5);
    chk("R7 i_max", int'(i_max), 5);
    chk("R8 i_min fallback", int'(i_min), 5);
    step(1, 0, 0, 110);
    chk("R4 i_last", int'(i_last), 10); chk("R4 i_open", int'(i_open), 0);
    chk("R6 i_max", int'(i_max), 10);   chk("R5 i_min", int'(i_min), 10);
    chk("R11 i_run", int'(i_run), 0);
  endtask

  task automatic t_shorter_longer();
    step(1, 1, 0, 200); step(1, 0, 0, 203);
    chk("R5 i_min", int'(i_min), 3); chk("R6 i_max", int'(i_max), 10);
    chk("R4 i_last", int'(i_last), 3);
    step(1, 1, 0, 300); step(1, 0, 0, 320);
    chk("R6 i_max", int'(i_max), 20); chk("R5 i_min", int'(i_min), 3);
    chk("R4 i_last", int'(i_last), 20);
  endtask

  task automatic t_no_strobe();
    step(0, 1, 1, 400);
    chk("R9 i_open", int'(i_open), 0); chk("R9 x_open", int'(x_open), 0);
    step(1, 1, 0, 410);
    step(0, 0, 0, 450);
    chk("R9 i_open held", int'(i_open), 1);
    chk("R9 i_last held", int'(i_last), 20);
    step(1, 0, 0, 415);
    chk("R4 i_last", int'(i_last), 5);
  endtask

  task automatic t_x_channel();
    step(1, 0, 1, 500);
    chk("R10 i_open", int'(i_open), 0); chk("R2 x_open", int'(x_open), 1);
    step(1, 0, 1, 510);
    chk("R7 x_max", int'(x_max), 10); chk("R8 x_min fallback", int'(x_min), 10);
    step(1, 0, 0, 512);
    chk("R4 x_last", int'(x_last), 12); chk("R5 x_min", int'(x_min), 12);
    chk("R10 i_last", int'(i_last), 5); chk("R10 i_max", int'(i_max), 20);
    chk("R10 i_min", int'(i_min), 3);
  endtask

  task automatic t_wrap();
    step(1, 0, 1, 16'hFFF0); step(1, 0, 0, 16'h0005);
    chk("R4 x_last wrap", int'(x_last), 21); chk("R6 x_max", int'(x_max), 21);
    chk("R5 x_min", int'(x_min), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_interval();
    t_shorter_longer();
    t_no_strobe();
    t_x_channel();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule